// File: doc/BRIEF.md
# Character-Cell Text Raster Generator

This block turns a single dot clock into the raster timing and serial pixel stream for a text screen of 80 visible columns by 24 visible text rows. A chain of counters tracks the dot within a character cell, the character position within a scan line, the scan within a text row and the text row within a frame. The row and column counts together form the address into an external video RAM. The byte read back is a character code, and it is turned into an address for an external glyph memory together with the low bits of the scan count.

Once per character time the block takes the returned glyph row and applies every blanking condition to it. The conditions are horizontal retrace, vertical retrace, the two-scan gap between text rows, the blink attribute in code bit 7, and a CPU access to video RAM. The block then latches the row into a shift register. The register shifts out one dot per dot clock while the counters move on to fetch the next cell. Horizontal and vertical sync leave the block as separate registered pins. When the CPU select input is high, the CPU address is passed through to the video RAM port in place of the raster address, and the picture goes dark after a short synchronizing delay.

Top module: `text_raster_gen`

## Requirements
- R1: A character boundary occurs every DOT_DIV (7) dot clocks. The first boundary acts on the 7th rising edge after reset is released, and the raster counters advance only on boundaries.
- R2: The column counts 0..CHARS-1 (128). The scan counts 0..SCANS-1 (10) and steps when the column wraps. The row counts 0..TOTAL_ROWS-1 (26) and steps when the scan wraps. With cpu_sel_i low, vram_addr_o = row*CHARS + column (CHARS is a power of two).
- R3: glyph_addr_o = {vram_data_i[6:0], scan[2:0]}, with the code in bits 9:3 and the glyph row in bits 2:0.
- R4: At each boundary the cell at the current column is latched. It is shown over the next 7 dot clocks: dot k (k = 0..4) equals NOT glyph_data_i[4-k], so a 0 bit is a lit dot. Dots 5 and 6 are dark, and glyph bits 7:5 have no effect.
- R5: Cells at columns ACTIVE_COLS (80) and above are dark.
- R6: hsync_o is high exactly while the column equals ACTIVE_COLS, delayed by one dot clock.
- R7: Cells on scans 8 and 9 of each text row are dark.
- R8: Cells on rows ACTIVE_ROWS (24) and above are dark. vsync_o is high exactly while the row equals ACTIVE_ROWS, delayed by one dot clock.
- R9: A cell whose code has bit 7 set is dark while the blink phase is high. The phase is low after reset and toggles every BLINK_FRAMES (16) frames.
- R10: With cpu_sel_i high, vram_addr_o equals cpu_addr_i in the same cycle. Video is dark from at most 3 character times after cpu_sel_i rises, and the normal picture returns at most 3 character times after it falls.
- R11: While rst_ni is low, video_o, hsync_o and vsync_o are low and vram_addr_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Dot clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_sel_i | input | 1 | CPU is accessing video RAM |
| cpu_addr_i | input | ADDR_W (12) | CPU address into video RAM |
| vram_addr_o | output | ADDR_W (12) | Video RAM address |
| vram_data_i | input | 8 | Character code read from video RAM |
| glyph_addr_o | output | 10 | Glyph memory address: code and glyph row |
| glyph_data_i | input | 8 | Glyph row bits, 0 = lit dot |
| video_o | output | 1 | Serial video, 1 = lit |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |

## Verification
Blink blanking and inter-row gap blanking can both apply to the same cell, and so can CPU-access blanking and ordinary glyph output. The bench runs several whole frames with a video RAM pattern in which many visible cells carry bit 7, so that the blink phase takes both values across frames while the same cells pass through the gap scans and the retrace columns. It then raises the CPU select in the middle of a visible row. The bench computes every expected dot from its own arithmetic model of the counter chain. It judges each dot against that model, tags a mismatch with the blanking reason that should have applied, and requires a fully dark window while the CPU select is held.

// File: rtl/text_raster_pkg.sv
package text_raster_pkg;
  localparam int DIV_CNT_W      = 4;
  localparam int CODE_W         = 8;
  localparam int BLINK_BIT      = CODE_W - 1;
  localparam int GLYPH_ROW_BITS = 3;
  localparam int GLYPH_ROWS     = 1 << GLYPH_ROW_BITS;
  localparam int GLYPH_DOTS     = 5;
  localparam int GLYPH_ADDR_W   = CODE_W - 1 + GLYPH_ROW_BITS;
endpackage

// File: rtl/char_clk_div.sv
module char_clk_div
  import text_raster_pkg::*;
#(
  parameter int DOT_DIV = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic char_stb_o
);
  localparam logic [DIV_CNT_W-1:0] RELOAD = DIV_CNT_W'((1 << DIV_CNT_W) - DOT_DIV);

  logic [DIV_CNT_W-1:0] cnt_q;

  // carry out of the counter is the character strobe
  assign char_stb_o = &cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= RELOAD;
    else if (char_stb_o) cnt_q <= RELOAD;
    else                 cnt_q <= cnt_q + 1'b1;
  end

  // R1
  div_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q >= RELOAD);
  // R1
  stb_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_stb_o |=> !char_stb_o);
endmodule

// File: rtl/raster_counters.sv
module raster_counters #(
  parameter int CHARS        = 128,
  parameter int SCANS        = 10,
  parameter int TOTAL_ROWS   = 26,
  parameter int BLINK_FRAMES = 16,
  localparam int COL_W  = $clog2(CHARS),
  localparam int SCAN_W = $clog2(SCANS),
  localparam int ROW_W  = $clog2(TOTAL_ROWS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              char_stb_i,
  output logic [COL_W-1:0]  col_o,
  output logic [SCAN_W-1:0] scan_o,
  output logic [ROW_W-1:0]  row_o,
  output logic              blink_o
);
  localparam int BF_W = $clog2(BLINK_FRAMES);
  localparam logic [COL_W-1:0]  COL_LAST  = COL_W'(CHARS - 1);
  localparam logic [SCAN_W-1:0] SCAN_LAST = SCAN_W'(SCANS - 1);
  localparam logic [ROW_W-1:0]  ROW_LAST  = ROW_W'(TOTAL_ROWS - 1);
  localparam logic [BF_W-1:0]   BF_LAST   = BF_W'(BLINK_FRAMES - 1);

  logic [BF_W-1:0] frame_q;
  logic line_end, row_end, frame_end;

  assign line_end  = char_stb_i && (col_o == COL_LAST);
  assign row_end   = line_end && (scan_o == SCAN_LAST);
  assign frame_end = row_end && (row_o == ROW_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_o   <= '0;
      scan_o  <= '0;
      row_o   <= '0;
      frame_q <= '0;
      blink_o <= 1'b0;
    end else begin
      if (char_stb_i) col_o  <= line_end ? '0 : col_o + 1'b1;
      if (line_end)   scan_o <= row_end ? '0 : scan_o + 1'b1;
      if (row_end)    row_o  <= frame_end ? '0 : row_o + 1'b1;
      if (frame_end) begin
        if (frame_q == BF_LAST) begin
          frame_q <= '0;
          blink_o <= ~blink_o;
        end else begin
          frame_q <= frame_q + 1'b1;
        end
      end
    end
  end

  // R2
  col_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_stb_i && col_o == COL_LAST) |=> (col_o == '0));
  // R2
  scan_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_o <= SCAN_LAST);
  // R2
  row_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_o <= ROW_LAST);
  // R9
  blink_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blink_o != $past(blink_o)) |-> $past(frame_end));
endmodule

// File: rtl/access_blank_sync.sv
module access_blank_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic char_stb_i,
  input  logic cpu_sel_i,
  output logic blank_o
);
  logic [STAGES-1:0] sync_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic d;
    if (i == 0) begin : g_first
      assign d = cpu_sel_i;
    end else begin : g_next
      assign d = sync_q[i-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         sync_q[i] <= 1'b0;
      else if (char_stb_i) sync_q[i] <= d;
    end
  end

  assign blank_o = sync_q[STAGES-1];

  // R10
  blank_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !char_stb_i |=> $stable(blank_o));
endmodule

// File: rtl/dot_shifter.sv
module dot_shifter #(
  parameter int WIDTH = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] pat_i,
  output logic             dot_o
);
  logic [WIDTH-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sh_q <= '0;
    else if (load_i) sh_q <= pat_i;
    else             sh_q <= {sh_q[WIDTH-2:0], 1'b0};
  end

  assign dot_o = sh_q[WIDTH-1];

  // R4
  first_dot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (dot_o == $past(pat_i[WIDTH-1])));
endmodule

// File: rtl/text_raster_gen.sv
module text_raster_gen
  import text_raster_pkg::*;
#(
  parameter int DOT_DIV      = 7,
  parameter int CHARS        = 128,
  parameter int ACTIVE_COLS  = 80,
  parameter int SCANS        = 10,
  parameter int ACTIVE_ROWS  = 24,
  parameter int TOTAL_ROWS   = 26,
  parameter int BLINK_FRAMES = 16,
  localparam int COL_W  = $clog2(CHARS),
  localparam int SCAN_W = $clog2(SCANS),
  localparam int ROW_W  = $clog2(TOTAL_ROWS),
  localparam int ADDR_W = ROW_W + COL_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cpu_sel_i,
  input  logic [ADDR_W-1:0]       cpu_addr_i,
  output logic [ADDR_W-1:0]       vram_addr_o,
  input  logic [CODE_W-1:0]       vram_data_i,
  output logic [GLYPH_ADDR_W-1:0] glyph_addr_o,
  input  logic [CODE_W-1:0]       glyph_data_i,
  output logic                    video_o,
  output logic                    hsync_o,
  output logic                    vsync_o
);
  localparam logic [COL_W-1:0]  HS_COL  = COL_W'(ACTIVE_COLS);
  localparam logic [ROW_W-1:0]  VS_ROW  = ROW_W'(ACTIVE_ROWS);
  localparam logic [SCAN_W-1:0] GAP_SCN = SCAN_W'(GLYPH_ROWS);

  logic              char_stb;
  logic [COL_W-1:0]  col_q;
  logic [SCAN_W-1:0] scan_q;
  logic [ROW_W-1:0]  row_q;
  logic              blink_q, cpu_blank, cell_blank;
  logic [DOT_DIV-1:0] pat;
  logic [CODE_W-GLYPH_DOTS-1:0] unused_glyph_bits;

  char_clk_div #(.DOT_DIV(DOT_DIV)) i_div (
    .clk_i, .rst_ni, .char_stb_o(char_stb)
  );

  raster_counters #(
    .CHARS(CHARS), .SCANS(SCANS), .TOTAL_ROWS(TOTAL_ROWS), .BLINK_FRAMES(BLINK_FRAMES)
  ) i_cnt (
    .clk_i, .rst_ni, .char_stb_i(char_stb),
    .col_o(col_q), .scan_o(scan_q), .row_o(row_q), .blink_o(blink_q)
  );

  access_blank_sync #(.STAGES(2)) i_sync (
    .clk_i, .rst_ni, .char_stb_i(char_stb), .cpu_sel_i, .blank_o(cpu_blank)
  );

  assign vram_addr_o  = cpu_sel_i ? cpu_addr_i : {row_q, col_q};
  assign glyph_addr_o = {vram_data_i[CODE_W-2:0], scan_q[GLYPH_ROW_BITS-1:0]};

  assign cell_blank = (col_q >= HS_COL) || (row_q >= VS_ROW) || (scan_q >= GAP_SCN)
                   || (vram_data_i[BLINK_BIT] && blink_q) || cpu_blank;

  // left-most dot comes from the highest used glyph bit
  for (genvar k = 0; k < DOT_DIV; k++) begin : g_dot
    if (k < GLYPH_DOTS) begin : g_used
      assign pat[DOT_DIV-1-k] = !glyph_data_i[GLYPH_DOTS-1-k] && !cell_blank;
    end else begin : g_pad
      assign pat[DOT_DIV-1-k] = 1'b0;
    end
  end
  assign unused_glyph_bits = glyph_data_i[CODE_W-1:GLYPH_DOTS];

  dot_shifter #(.WIDTH(DOT_DIV)) i_shift (
    .clk_i, .rst_ni, .load_i(char_stb), .pat_i(pat), .dot_o(video_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hsync_o <= 1'b0;
      vsync_o <= 1'b0;
    end else begin
      hsync_o <= (col_q == HS_COL);
      vsync_o <= (row_q == VS_ROW);
    end
  end

  // R6
  hsync_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hsync_o) |-> (col_q == HS_COL));
  // R8
  vsync_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vsync_o) |-> (row_q == VS_ROW));
  // R5
  hblank_dark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_stb && col_q >= HS_COL) |=> !video_o);
  // R7
  gap_dark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_stb && scan_q >= GAP_SCN) |=> !video_o);
endmodule

// File: tb/test_text_raster_gen.sv
module test_text_raster_gen;
  localparam int DIV = 7, C = 16, HA = 10, S = 10, VA = 3, R = 5, BF = 2;
  localparam int FRAME = DIV * C * S * R;

  logic       clk = 1'b0, rst_n = 1'b0, cpu_sel = 1'b0;
  logic [6:0] cpu_addr = '0;
  logic [6:0] vram_addr;
  logic [7:0] vram_data, glyph_data;
  logic [9:0] glyph_addr;
  logic       video, hsync, vsync;
  int n = 0, checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) if (rst_n) n <= n + 1;

  function automatic logic [7:0] vcode(int a);
    return 8'(a * 37 + 5);
  endfunction
  function automatic logic [7:0] gfun(logic [9:0] a);
    return 8'(a[9:3] * 5) ^ {5'b0, a[2:0]};
  endfunction

  always_comb vram_data  = vcode(int'(vram_addr));
  always_comb glyph_data = gfun(glyph_addr);

  text_raster_gen #(
    .DOT_DIV(DIV), .CHARS(C), .ACTIVE_COLS(HA), .SCANS(S),
    .ACTIVE_ROWS(VA), .TOTAL_ROWS(R), .BLINK_FRAMES(BF)
  ) i_text_raster_gen (
    .clk_i(clk), .rst_ni(rst_n), .cpu_sel_i(cpu_sel), .cpu_addr_i(cpu_addr),
    .vram_addr_o(vram_addr), .vram_data_i(vram_data), .glyph_addr_o(glyph_addr),
    .glyph_data_i(glyph_data), .video_o(video), .hsync_o(hsync), .vsync_o(vsync)
  );

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s at dot %0d: actual=%0d expected=%0d", tag, what, n, act, exp);
    end
  endtask

  // expected video after edge nn, with the rule that decides it
  function automatic logic exp_video(int nn, output string tag);
    int p, d, col, sc, row, fr;
    logic [7:0] code, g;
    tag = "R4";
    if (nn < DIV) begin tag = "R11"; return 1'b0; end
    p = nn / DIV - 1; d = nn % DIV;
    col = p % C; sc = (p / C) % S; row = (p / (C * S)) % R; fr = p / (C * S * R);
    if (col >= HA) begin tag = "R5"; return 1'b0; end
    if (row >= VA) begin tag = "R8"; return 1'b0; end
    if (sc >= 8)   begin tag = "R7"; return 1'b0; end
    code = vcode(row * C + col);
    if (code[7] && ((fr / BF) % 2 == 1)) begin tag = "R9"; return 1'b0; end
    if (d >= 5) return 1'b0;
    g = gfun({code[6:0], 3'(sc)});
    return ~g[4 - d];
  endfunction

  function automatic int exp_addr(int nn);
    int q = nn / DIV;
    return ((q / (C * S)) % R) * C + q % C;
  endfunction

  task automatic compare_window(int cycles);
    for (int i = 0; i < cycles; i++) begin
      string tag;
      logic ev;
      int q, hq, ea;
      logic [9:0] eg;
      @(negedge clk);
      ev = exp_video(n, tag);
      chk(video == ev, tag, "video", video, ev);
      hq = (n - 1) / DIV;
      chk(hsync == ((hq % C) == HA), "R6", "hsync", hsync, int'((hq % C) == HA));
      chk(vsync == (((hq / (C * S)) % R) == VA), "R8", "vsync", vsync,
          int'(((hq / (C * S)) % R) == VA));
      ea = exp_addr(n);
      chk(int'(vram_addr) == ea, "R2", "vram_addr", vram_addr, ea);
      q = n / DIV;
      eg = {vcode(ea)[6:0], 3'((q / C) % S)};
      chk(glyph_addr == eg, "R3", "glyph_addr", glyph_addr, eg);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(video == 1'b0, "R11", "video in reset", video, 0);
    chk(hsync == 1'b0, "R11", "hsync in reset", hsync, 0);
    chk(vsync == 1'b0, "R11", "vsync in reset", vsync, 0);
    chk(vram_addr == '0, "R11", "vram_addr in reset", vram_addr, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_char_boundary;
    for (int i = 0; i < 2 * DIV; i++) begin
      @(negedge clk);
      chk(int'(vram_addr) == n / DIV, "R1", "column step", vram_addr, n / DIV);
    end
  endtask

  task automatic t_line;
    compare_window(C * DIV);
  endtask

  task automatic t_frame;
    while (n < FRAME) compare_window(1);
  endtask

  task automatic t_blink;
    while (n < 4 * FRAME) compare_window(1);
  endtask

  task automatic t_cpu_access;
    @(negedge clk);
    cpu_sel = 1'b1; cpu_addr = 7'h2A;
    #1 chk(vram_addr == 7'h2A, "R10", "cpu address pass", vram_addr, 7'h2A);
    repeat (3 * DIV + 1) @(negedge clk);
    for (int i = 0; i < 3 * DIV; i++) begin
      @(negedge clk);
      chk(video == 1'b0, "R10", "video during cpu access", video, 0);
      chk(vram_addr == 7'h2A, "R10", "cpu address held", vram_addr, 7'h2A);
    end
    cpu_sel = 1'b0;
    repeat (3 * DIV + 1) @(negedge clk);
    compare_window(C * S * DIV);
  endtask

  initial begin
    t_reset();
    t_char_boundary();
    t_line();
    t_frame();
    t_blink();
    t_cpu_access();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired at dot %0d: actual=running expected=done", n);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule